// File: doc/BRIEF.md
# Wishbone Register Access Bridge

This block sits between a Wishbone bus master and a simple register file. It takes classic single-read and single-write cycles, holds one command at a time, and turns it into a one-cycle request toward the register file. The request carries a direction flag, an address, write data and a per-bit write mask built from the byte selects. The register file answers with a done pulse, its read data and two fault flags. The first flag reports that no register sits at the address. The second reports that the access goes the wrong way: a write to a read-only register or a read from a write-only one.

The bridge turns that answer into either an acknowledge or an error pulse toward the master, never both. Each of the two fault checks can be switched on or off by a parameter. When a check is off, the matching fault is acknowledged as a normal transfer and reads return zero. The bus cycle input exists only for completeness, because a command starts on strobe alone. Burst and pipelined cycle types are not handled.

Top module: `wbreg_bridge`

## Requirements
- R1: While reset is high, and in the first cycle after it, stall, acknowledge, error and the register request are low, read data is zero, and any pending command is dropped.
- R2: When strobe is high at a clock edge and stall is low, the command is captured. The register request is high for exactly the next cycle, carrying the captured address and direction (1 = write). The cycle input has no effect on this.
- R3: Stall goes high in the cycle after capture and stays high through the response cycle, falling in the cycle after it. Strobe seen while stall is high starts no command.
- R4: Write mask bit 8*i+j equals byte select i. Write data toward the register file is the bus write data with unselected byte lanes forced to zero.
- R5: If done is sampled high while a request is waiting, acknowledge or error is high for exactly the next cycle. Done seen while no request is waiting, or during the response cycle, is ignored. The request cycle itself counts as waiting.
- R6: Acknowledge and error are never high in the same cycle.
- R7: With address checking enabled, a done that comes with the unmapped flag ends in error and not acknowledge.
- R8: With direction checking enabled, a done that comes with the direction-fault flag ends in error and not acknowledge.
- R9: With a check disabled, the matching fault is acknowledged and the read data returned is zero.
- R10: In the acknowledge cycle of a fault-free read, read data equals the register file data sampled with done. In every other cycle, including write acknowledges, read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle flag, unused |
| wb_stb_i | input | 1 | Strobe, starts a command |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Register address |
| wb_wdat_i | input | DATA_W | Write data from master |
| wb_sel_i | input | DATA_W/8 | Byte lane selects |
| wb_stall_o | output | 1 | Bridge busy, new command not accepted |
| wb_ack_o | output | 1 | Transfer completed normally |
| wb_err_o | output | 1 | Transfer ended with error |
| wb_rdat_o | output | DATA_W | Read data to master |
| rf_req_o | output | 1 | One-cycle access request |
| rf_write_o | output | 1 | Request direction, 1 = write |
| rf_addr_o | output | ADDR_W | Request address |
| rf_wdata_o | output | DATA_W | Lane-masked write data |
| rf_wmask_o | output | DATA_W | Per-bit write enable |
| rf_rdata_i | input | DATA_W | Register read data, valid with done |
| rf_done_i | input | 1 | Access completion pulse |
| rf_unmapped_i | input | 1 | No register at the address |
| rf_dir_fault_i | input | 1 | Access direction not allowed |

## Verification
The hardest situations to reach are the edge overlaps. A done can arrive in the very cycle the request is raised. Strobe can still be high during the response cycle. A done can turn up while the bridge is idle or already responding. A stream of independently random strobe, done and fault inputs, with strobe held high most of the time, reaches all of these often. Two instances, one with both checks enabled and one with both disabled, share that stimulus. A behavioural model predicts every output of each instance on every clock, and a reset is applied in the middle of traffic to drop a pending command.

// File: rtl/wbreg_pkg.sv
package wbreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } brg_state_e;

    typedef struct packed {
        logic is_err;
        logic pass_data;
    } verdict_t;

    localparam int unsigned LANE_W = 8;

    function automatic verdict_t judge_access(
        input logic chk_addr,
        input logic chk_dir,
        input logic is_write,
        input logic unmapped,
        input logic dir_fault
    );
        verdict_t v;
        v.is_err    = (chk_addr & unmapped) | (chk_dir & dir_fault);
        v.pass_data = ~v.is_err & ~is_write & ~unmapped & ~dir_fault;
        return v;
    endfunction

endpackage

// File: rtl/wbreg_capture.sv
module wbreg_capture
    import wbreg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [DATA_W-1:0] wdat_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              done_i,
    output brg_state_e        state_o,
    output logic              req_o,
    output logic              we_q,
    output logic [ADDR_W-1:0] adr_q,
    output logic [DATA_W-1:0] wdat_q,
    output logic [SEL_W-1:0]  sel_q
);

    brg_state_e state_q;
    brg_state_e state_d;
    logic       take;

    assign take = (state_q == ST_IDLE) && stb_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (stb_i)  state_d = ST_WAIT;
            ST_WAIT: if (done_i) state_d = ST_RESP;
            ST_RESP:             state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_o   <= 1'b0;
            we_q    <= 1'b0;
            adr_q   <= '0;
            wdat_q  <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            req_o   <= take;
            if (take) begin
                we_q   <= we_i;
                adr_q  <= adr_i;
                wdat_q <= wdat_i;
                sel_q  <= sel_i;
            end
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/wbreg_judge.sv
module wbreg_judge
    import wbreg_pkg::*;
#(
    parameter bit CHK_ADDR = 1'b1,
    parameter bit CHK_DIR  = 1'b1
) (
    input  logic     is_write_i,
    input  logic     unmapped_i,
    input  logic     dir_fault_i,
    output verdict_t verdict_o
);

    assign verdict_o = judge_access(CHK_ADDR, CHK_DIR, is_write_i,
                                    unmapped_i, dir_fault_i);

endmodule

// File: rtl/wbreg_respond.sv
module wbreg_respond
    import wbreg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  verdict_t          verdict_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              ack_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdat_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o  <= 1'b0;
            err_o  <= 1'b0;
            rdat_o <= '0;
        end else if (fire_i) begin
            ack_o  <= ~verdict_i.is_err;
            err_o  <= verdict_i.is_err;
            rdat_o <= verdict_i.pass_data ? rdata_i : '0;
        end else begin
            ack_o  <= 1'b0;
            err_o  <= 1'b0;
            rdat_o <= '0;
        end
    end

endmodule

// File: rtl/wbreg_bridge.sv
module wbreg_bridge
    import wbreg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter bit          CHK_ADDR = 1'b1,
    parameter bit          CHK_DIR  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wb_cyc_i,
    input  logic                       wb_stb_i,
    input  logic                       wb_we_i,
    input  logic [ADDR_W-1:0]          wb_adr_i,
    input  logic [DATA_W-1:0]          wb_wdat_i,
    input  logic [DATA_W/LANE_W-1:0]   wb_sel_i,
    output logic                       wb_stall_o,
    output logic                       wb_ack_o,
    output logic                       wb_err_o,
    output logic [DATA_W-1:0]          wb_rdat_o,
    output logic                       rf_req_o,
    output logic                       rf_write_o,
    output logic [ADDR_W-1:0]          rf_addr_o,
    output logic [DATA_W-1:0]          rf_wdata_o,
    output logic [DATA_W-1:0]          rf_wmask_o,
    input  logic [DATA_W-1:0]          rf_rdata_i,
    input  logic                       rf_done_i,
    input  logic                       rf_unmapped_i,
    input  logic                       rf_dir_fault_i
);

    localparam int unsigned SEL_W = DATA_W / LANE_W;

    brg_state_e        state;
    logic              we_q;
    logic [DATA_W-1:0] wdat_q;
    logic [SEL_W-1:0]  sel_q;
    logic              fire;
    verdict_t          verdict;
    logic              unused_cyc;

    // The cycle flag carries no information for single transfers.
    assign unused_cyc = wb_cyc_i;

    wbreg_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .stb_i   (wb_stb_i),
        .we_i    (wb_we_i),
        .adr_i   (wb_adr_i),
        .wdat_i  (wb_wdat_i),
        .sel_i   (wb_sel_i),
        .done_i  (rf_done_i),
        .state_o (state),
        .req_o   (rf_req_o),
        .we_q    (we_q),
        .adr_q   (rf_addr_o),
        .wdat_q  (wdat_q),
        .sel_q   (sel_q)
    );

    // Byte selects fan out to a per-bit mask; unselected lanes carry zero.
    for (genvar g = 0; g < SEL_W; g++) begin : g_lane
        assign rf_wmask_o[g*LANE_W +: LANE_W] = {LANE_W{sel_q[g]}};
        assign rf_wdata_o[g*LANE_W +: LANE_W] =
            wdat_q[g*LANE_W +: LANE_W] & {LANE_W{sel_q[g]}};
    end

    assign rf_write_o = we_q;
    assign wb_stall_o = (state != ST_IDLE);
    assign fire       = (state == ST_WAIT) && rf_done_i;

    wbreg_judge #(
        .CHK_ADDR (CHK_ADDR),
        .CHK_DIR  (CHK_DIR)
    ) u_judge (
        .is_write_i  (we_q),
        .unmapped_i  (rf_unmapped_i),
        .dir_fault_i (rf_dir_fault_i),
        .verdict_o   (verdict)
    );

    wbreg_respond #(
        .DATA_W (DATA_W)
    ) u_respond (
        .clk       (clk),
        .rst       (rst),
        .fire_i    (fire),
        .verdict_i (verdict),
        .rdata_i   (rf_rdata_i),
        .ack_o     (wb_ack_o),
        .err_o     (wb_err_o),
        .rdat_o    (wb_rdat_o)
    );

endmodule

// File: rtl/wbreg_bridge_chk.sv
module wbreg_bridge_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter bit          CHK_ADDR = 1'b1,
    parameter bit          CHK_DIR  = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              ack,
    input logic              err,
    input logic [DATA_W-1:0] rdat,
    input logic              req,
    input logic [ADDR_W-1:0] addr,
    input logic              done,
    input logic              unmapped,
    input logic              dir_fault
);

    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ack && err)); // R6

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ack || err) |=> !(ack || err)); // R5

    AST_RESP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (ack || err) |-> ($past(done) && $past(stall) && stall)); // R5

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req |-> stall ##1 !req); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (stall && !req) |-> $stable(addr)); // R3

    AST_RDAT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ack |-> (rdat == '0)); // R10

    AST_FAULT_TO_ERR: assert property (@(posedge clk) disable iff (rst)
        err |-> $past((CHK_ADDR && unmapped) || (CHK_DIR && dir_fault))); // R7

endmodule

bind wbreg_bridge wbreg_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CHK_ADDR (CHK_ADDR),
    .CHK_DIR  (CHK_DIR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (wb_stall_o),
    .ack       (wb_ack_o),
    .err       (wb_err_o),
    .rdat      (wb_rdat_o),
    .req       (rf_req_o),
    .addr      (rf_addr_o),
    .done      (rf_done_i),
    .unmapped  (rf_unmapped_i),
    .dir_fault (rf_dir_fault_i)
);

// File: tb/wbreg_bridge_tb.sv
module wbreg_bridge_tb;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam int NCYC = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          cyc, stb, we, done, unm, dirf;
    logic [AW-1:0] adr;
    logic [DW-1:0] wdat, rfd;
    logic [SW-1:0] sel;

    logic          stall_a, ack_a, err_a, req_a, wr_a;
    logic [DW-1:0] rdat_a, rwd_a, rwm_a;
    logic [AW-1:0] radr_a;
    logic          stall_b, ack_b, err_b, req_b, wr_b;
    logic [DW-1:0] rdat_b, rwd_b, rwm_b;
    logic [AW-1:0] radr_b;

    wbreg_bridge #(.ADDR_W(AW), .DATA_W(DW), .CHK_ADDR(1'b1), .CHK_DIR(1'b1)) u_dut (
        .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_wdat_i(wdat), .wb_sel_i(sel),
        .wb_stall_o(stall_a), .wb_ack_o(ack_a), .wb_err_o(err_a), .wb_rdat_o(rdat_a),
        .rf_req_o(req_a), .rf_write_o(wr_a), .rf_addr_o(radr_a),
        .rf_wdata_o(rwd_a), .rf_wmask_o(rwm_a), .rf_rdata_i(rfd),
        .rf_done_i(done), .rf_unmapped_i(unm), .rf_dir_fault_i(dirf));

    wbreg_bridge #(.ADDR_W(AW), .DATA_W(DW), .CHK_ADDR(1'b0), .CHK_DIR(1'b0)) u_dut_nochk (
        .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_wdat_i(wdat), .wb_sel_i(sel),
        .wb_stall_o(stall_b), .wb_ack_o(ack_b), .wb_err_o(err_b), .wb_rdat_o(rdat_b),
        .rf_req_o(req_b), .rf_write_o(wr_b), .rf_addr_o(radr_b),
        .rf_wdata_o(rwd_b), .rf_wmask_o(rwm_b), .rf_rdata_i(rfd),
        .rf_done_i(done), .rf_unmapped_i(unm), .rf_dir_fault_i(dirf));

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: phase 0 idle, 1 waiting, 2 responding.
    int            m_phase = 0;
    bit            m_req = 0, m_we = 0, m_rst = 1;
    logic [AW-1:0] m_adr = '0;
    logic [DW-1:0] m_wdat = '0;
    logic [SW-1:0] m_sel = '0;
    bit            m_ack[2], m_err[2];
    logic [DW-1:0] m_rd[2];
    string         m_tag[2];

    function automatic logic [DW-1:0] lane_mask(input logic [SW-1:0] s);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < DW; i++) r[i] = s[i/8];
        return r;
    endfunction

    task automatic model_step();
        int            nphase;
        bit            nreq;
        nphase = m_phase;
        nreq   = 0;
        for (int k = 0; k < 2; k++) begin
            m_ack[k] = 0; m_err[k] = 0; m_rd[k] = '0;
        end
        if (rst) begin
            nphase = 0; m_rst = 1;
        end else begin
            m_rst = 0;
            if (m_phase == 0 && stb) begin
                nphase = 1; nreq = 1;
                m_we = we; m_adr = adr; m_wdat = wdat; m_sel = sel;
            end else if (m_phase == 1 && done) begin
                nphase = 2;
                // k = 0: both checks on; k = 1: both checks off
                m_err[0] = unm || dirf;
                m_ack[0] = !m_err[0];
                m_tag[0] = unm ? "R7" : (dirf ? "R8" : "R5");
                m_ack[1] = 1;
                m_tag[1] = (unm || dirf) ? "R9" : "R5";
                for (int k = 0; k < 2; k++)
                    if (m_ack[k] && !m_we && !unm && !dirf) m_rd[k] = rfd;
            end else if (m_phase == 2) begin
                nphase = 0;
            end
        end
        m_phase = nphase;
        m_req   = nreq;
    endtask

    task automatic compare(input int k, input logic st, ak, er, rq, wr,
                           input logic [AW-1:0] ra, input logic [DW-1:0] rd, wd, wm);
        string t;
        t = m_rst ? "R1" : "R3";
        chk(st === (m_phase != 0), t, st, m_phase != 0);
        t = m_rst ? "R1" : m_tag[k];
        chk(ak === m_ack[k], {t, " ack"}, ak, m_ack[k]);
        chk(er === m_err[k], {t, " err"}, er, m_err[k]);
        chk(!(ak && er), "R6", {ak, er}, 2'b00);
        t = m_rst ? "R1" : ((k == 1 && m_tag[k] == "R9") ? "R9" : "R10");
        chk(rd === m_rd[k], t, rd, m_rd[k]);
        t = m_rst ? "R1" : "R2";
        chk(rq === m_req, t, rq, m_req);
        if (m_req && !m_rst) begin
            chk(ra === m_adr, "R2 addr", ra, m_adr);
            chk(wr === m_we, "R2 dir", wr, m_we);
            chk(wm === lane_mask(m_sel), "R4 mask", wm, lane_mask(m_sel));
            chk(wd === (m_wdat & lane_mask(m_sel)), "R4 data", wd, m_wdat & lane_mask(m_sel));
        end
    endtask

    initial begin
        cyc = 0; stb = 1; we = 0; adr = '0; wdat = '0; sel = '0;
        done = 0; unm = 0; dirf = 0; rfd = '0;
        for (int k = 0; k < 2; k++) begin
            m_ack[k] = 0; m_err[k] = 0; m_rd[k] = '0; m_tag[k] = "R5";
        end
        model_step();
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            compare(0, stall_a, ack_a, err_a, req_a, wr_a, radr_a, rdat_a, rwd_a, rwm_a);
            compare(1, stall_b, ack_b, err_b, req_b, wr_b, radr_b, rdat_b, rwd_b, rwm_b);
            // R1: reset at start and once in the middle of traffic
            rst  = (c < 3) || (c >= 2000 && c < 2003);
            cyc  = 1'($urandom_range(0, 1));
            stb  = ($urandom_range(0, 9) < 7);
            we   = 1'($urandom_range(0, 1));
            adr  = AW'($urandom);
            wdat = $urandom;
            sel  = SW'($urandom);
            done = ($urandom_range(0, 9) < 4);
            unm  = ($urandom_range(0, 3) == 0);
            dirf = ($urandom_range(0, 3) == 0);
            rfd  = $urandom;
            model_step();
        end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * (NCYC + 200));
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule